// File: doc/BRIEF.md
# Parallel Disk Task-File Register Interface

This block is the device-side register file of a parallel disk drive. The host reaches it through two active-low chip selects, three address lines and active-low read and write strobes. All host inputs pass through a two-flop synchronizer into the device clock. After that, the block decodes each access to a command-block register (task-file parameters, error, status and command) or to a control-block register (alternate status, device control and drive address).

The task-file parameters go to the media engine as plain outputs. An accepted command write gives the media engine a one-cycle opcode pulse. The media engine sets the status byte, the write-gate level, the error code and interrupt requests. Data-port accesses become 16-bit word pulses toward an external sector buffer while the drive requests data. The block also holds the software-reset and interrupt-disable bits, and it drives the interrupt pin and its tri-state enable.

Read data and the per-bit bus enable are registered. The host must hold its chip selects, address and data stable for several device clocks around each strobe.

Top module: `pata_taskfile`

## Requirements
- R1: After reset, the read values are: error 01h, sector count 01h, sector number 01h, cylinder low 00h, cylinder high 00h and drive/head A0h. A byte read enables only data bits 7..0 (`host_rd_oe` = 00FFh).
- R2: A command-block access has `host_cs_cmd_n` low and `host_cs_ctl_n` high. Addresses 2, 3, 4 and 5 write and read back sector count, sector number, cylinder low and cylinder high.
- R3: A drive/head read returns bit 7 = 1, bit 6 = 0, bit 5 = 1, bit 4 = drive select and bits 3..0 = head number, as last written.
- R4: The status byte is `{busy, dev_status[6:0]}`, where busy = `dev_status[7]` OR the software-reset bit. While busy is set, command-block writes are ignored, including the command write, and a read at any command-block address returns the status byte.
- R5: A write to address 7 while not busy gives exactly one `cmd_valid` pulse carrying the written opcode. A write to address 1 (precompensation) changes no readable register.
- R6: A control-block access has `host_cs_ctl_n` low and `host_cs_cmd_n` high. Address 6 reads the status byte. Address 7 reads the drive-address byte `{float, ~dev_wgate, ~head[3:0], ~(drv==1), ~(drv==0)}` with `host_rd_oe` = 007Fh. Other control addresses drive nothing on read and ignore writes.
- R7: When both chip selects are low, or both are high, nothing is driven on read and writes are ignored.
- R8: A device-control write (control address 6) stores bit 2 as software reset and bit 1 as interrupt disable. While software reset is set, the task file is held at its R1 values and busy reads as set.
- R9: A one-cycle `dev_irq_set` makes an interrupt pending (`host_irq` = 1). A status read, a command write and software reset clear it. An alternate-status read does not clear it.
- R10: `host_irq_oe` is 1 only when interrupt disable is 0 and the stored drive select equals `drive_id`.
- R11: While `dev_status[3]` (data request) is set and busy is clear, an access to address 0 has the following effects. `host_iocs16_n` goes low. A read returns `buf_rdata` with `host_rd_oe` = FFFFh. The end of a read pulses `buf_rd_pulse` once. The end of a write pulses `buf_wr_pulse` once, with `buf_wdata` holding the written word. With data request clear, there are no pulses and `host_iocs16_n` stays high.
- R12: A one-cycle `dev_err_load` copies `dev_err_code` into the error register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_cmd_n | input | 1 | Command-block chip select, active low |
| host_cs_ctl_n | input | 1 | Control-block chip select, active low |
| host_addr | input | 3 | Register address |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low; data taken at its rising edge |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data toward the host |
| host_rd_oe | output | 16 | Per-bit drive enable for host_rdata |
| host_iocs16_n | output | 1 | 16-bit data-port indication, active low |
| host_irq | output | 1 | Interrupt pending level |
| host_irq_oe | output | 1 | Drive enable of the interrupt pin |
| drive_id | input | 1 | This drive's number (0 or 1) |
| dev_status | input | 8 | Status from the media engine (bit 7 busy, bit 3 data request) |
| dev_wgate | input | 1 | Write gate active |
| dev_irq_set | input | 1 | One-cycle interrupt request |
| dev_err_load | input | 1 | One-cycle error-register load |
| dev_err_code | input | 8 | Error code to load |
| tf_sect_cnt | output | 8 | Sector count |
| tf_sect_num | output | 8 | Sector number |
| tf_cyl | output | 16 | Cylinder (high byte, low byte) |
| tf_drv | output | 1 | Drive select |
| tf_head | output | 4 | Head number |
| srst_out | output | 1 | Software reset held |
| cmd_valid | output | 1 | One-cycle accepted-command pulse |
| cmd_opcode | output | 8 | Opcode of the last accepted command |
| buf_rdata | input | 16 | Word from the sector buffer |
| buf_rd_pulse | output | 1 | One-cycle word-read pulse |
| buf_wdata | output | 16 | Word toward the sector buffer |
| buf_wr_pulse | output | 1 | One-cycle word-write pulse |

## Verification
Most internal faults show up at the host bus on the next read, about three clocks after the strobe falls. A corrupted task-file register reads back wrong. A stale busy term returns the status byte in place of a register. A wrong drive select shows in the drive/head byte, in the drive-address byte and in `host_irq_oe` at once. A faulty interrupt flag shows on `host_irq` one clock after the event that should set or clear it. Edge-detect faults in the strobe path cause missing or doubled `cmd_valid` and buffer pulses, and the bench counts these directly.

// File: rtl/pata_tf_pkg.sv
package pata_tf_pkg;
  localparam int unsigned TF_ADDR_W = 3;
  localparam int unsigned TF_BYTE_W = 8;

  // command-block addresses
  localparam logic [TF_ADDR_W-1:0] CA_DATA   = 3'd0;
  localparam logic [TF_ADDR_W-1:0] CA_PRECMP = 3'd1;
  localparam logic [TF_ADDR_W-1:0] CA_SCNT   = 3'd2;
  localparam logic [TF_ADDR_W-1:0] CA_SNUM   = 3'd3;
  localparam logic [TF_ADDR_W-1:0] CA_CYLLO  = 3'd4;
  localparam logic [TF_ADDR_W-1:0] CA_CYLHI  = 3'd5;
  localparam logic [TF_ADDR_W-1:0] CA_DRVHD  = 3'd6;
  localparam logic [TF_ADDR_W-1:0] CA_STCMD  = 3'd7;
  // control-block addresses
  localparam logic [TF_ADDR_W-1:0] KA_ALTDEV = 3'd6;
  localparam logic [TF_ADDR_W-1:0] KA_DRVADR = 3'd7;

  // bit positions
  localparam int unsigned ST_BUSY = 7;
  localparam int unsigned ST_DRQ  = 3;
  localparam int unsigned DC_SRST = 2;
  localparam int unsigned DC_NIEN = 1;
  localparam int unsigned DH_DRV  = 4;

  // reset values
  localparam logic [TF_BYTE_W-1:0] RV_ERR  = 8'h01;
  localparam logic [TF_BYTE_W-1:0] RV_SCNT = 8'h01;
  localparam logic [TF_BYTE_W-1:0] RV_SNUM = 8'h01;
  localparam logic [TF_BYTE_W-1:0] RV_CYL  = 8'h00;

  typedef struct packed {
    logic                 cmd_sel;
    logic                 ctl_sel;
    logic [TF_ADDR_W-1:0] addr;
  } tf_sel_t;
endpackage

// File: rtl/pata_sync.sv
module pata_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pata_tf_decode.sv
module pata_tf_decode
  import pata_tf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_cmd_n,
  input  logic                 cs_ctl_n,
  input  logic [TF_ADDR_W-1:0] addr,
  input  logic                 rd_n,
  input  logic                 wr_n,
  output tf_sel_t              sel,
  output logic                 rd_active,
  output logic                 rd_start,
  output logic                 rd_end,
  output logic                 wr_end
);
  logic rd_n_q, wr_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
    end else begin
      rd_n_q <= rd_n;
      wr_n_q <= wr_n;
    end
  end

  always_comb begin
    sel.cmd_sel = !cs_cmd_n &&  cs_ctl_n;
    sel.ctl_sel =  cs_cmd_n && !cs_ctl_n;
    sel.addr    = addr;
    rd_active   = !rd_n;
    rd_start    = !rd_n &&  rd_n_q;
    rd_end      =  rd_n && !rd_n_q;
    wr_end      =  wr_n && !wr_n_q;
  end
endmodule

// File: rtl/pata_tf_regs.sv
module pata_tf_regs
  import pata_tf_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tf_sel_t              sel,
  input  logic                 rd_start,
  input  logic                 rd_end,
  input  logic                 wr_end,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 dev_busy,
  input  logic                 dev_drq,
  input  logic                 dev_irq_set,
  input  logic                 dev_err_load,
  input  logic [TF_BYTE_W-1:0] dev_err_code,
  output logic                 busy_eff,
  output logic [TF_BYTE_W-1:0] err_o,
  output logic [TF_BYTE_W-1:0] scnt_o,
  output logic [TF_BYTE_W-1:0] snum_o,
  output logic [TF_BYTE_W-1:0] cyllo_o,
  output logic [TF_BYTE_W-1:0] cylhi_o,
  output logic                 drv_o,
  output logic [3:0]           head_o,
  output logic                 srst_o,
  output logic                 nien_o,
  output logic                 irq_o,
  output logic                 cmdv_o,
  output logic [TF_BYTE_W-1:0] opc_o,
  output logic                 brd_o,
  output logic                 bwr_o,
  output logic [DATA_W-1:0]    bwdata_o
);
  logic [TF_BYTE_W-1:0] err_q, err_d, scnt_q, scnt_d, snum_q, snum_d;
  logic [TF_BYTE_W-1:0] cyllo_q, cyllo_d, cylhi_q, cylhi_d, opc_q, opc_d;
  logic                 drv_q, drv_d, srst_q, srst_d, nien_q, nien_d, irq_q, irq_d;
  logic                 cmdv_q, cmdv_d, brd_q, brd_d, bwr_q, bwr_d;
  logic [3:0]           head_q, head_d;
  logic [DATA_W-1:0]    bw_q, bw_d;
  logic                 cmd_wr, port_ok, stat_rd, irq_clr;

  assign busy_eff = dev_busy || srst_q;
  assign port_ok  = dev_drq && !busy_eff;

  always_comb begin
    err_d = err_q;  scnt_d = scnt_q;  snum_d = snum_q;
    cyllo_d = cyllo_q;  cylhi_d = cylhi_q;  drv_d = drv_q;  head_d = head_q;
    srst_d = srst_q;  nien_d = nien_q;  irq_d = irq_q;  opc_d = opc_q;
    cmdv_d = 1'b0;  brd_d = 1'b0;  bwr_d = 1'b0;  bw_d = bw_q;

    cmd_wr  = wr_end && sel.cmd_sel && !busy_eff;
    stat_rd = rd_start && sel.cmd_sel && (sel.addr == CA_STCMD);
    irq_clr = stat_rd || (cmd_wr && (sel.addr == CA_STCMD));

    if (cmd_wr) begin
      case (sel.addr)
        CA_DATA: if (dev_drq) begin
          bwr_d = 1'b1;
          bw_d  = wdata;
        end
        CA_SCNT:  scnt_d  = wdata[TF_BYTE_W-1:0];
        CA_SNUM:  snum_d  = wdata[TF_BYTE_W-1:0];
        CA_CYLLO: cyllo_d = wdata[TF_BYTE_W-1:0];
        CA_CYLHI: cylhi_d = wdata[TF_BYTE_W-1:0];
        CA_DRVHD: begin
          drv_d  = wdata[DH_DRV];
          head_d = wdata[3:0];
        end
        CA_STCMD: begin
          cmdv_d = 1'b1;
          opc_d  = wdata[TF_BYTE_W-1:0];
        end
        default: ;
      endcase
    end

    if (rd_end && sel.cmd_sel && (sel.addr == CA_DATA) && port_ok) brd_d = 1'b1;

    if (dev_err_load) err_d = dev_err_code;

    if (wr_end && sel.ctl_sel && (sel.addr == KA_ALTDEV)) begin
      srst_d = wdata[DC_SRST];
      nien_d = wdata[DC_NIEN];
    end

    if (dev_irq_set)  irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;

    if (srst_q) begin
      err_d = RV_ERR;  scnt_d = RV_SCNT;  snum_d = RV_SNUM;
      cyllo_d = RV_CYL;  cylhi_d = RV_CYL;  drv_d = 1'b0;  head_d = 4'h0;
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= RV_ERR;  scnt_q <= RV_SCNT;  snum_q <= RV_SNUM;
      cyllo_q <= RV_CYL;  cylhi_q <= RV_CYL;  drv_q <= 1'b0;  head_q <= 4'h0;
      srst_q <= 1'b0;  nien_q <= 1'b0;  irq_q <= 1'b0;
      cmdv_q <= 1'b0;  opc_q <= '0;  brd_q <= 1'b0;  bwr_q <= 1'b0;  bw_q <= '0;
    end else begin
      err_q <= err_d;  scnt_q <= scnt_d;  snum_q <= snum_d;
      cyllo_q <= cyllo_d;  cylhi_q <= cylhi_d;  drv_q <= drv_d;  head_q <= head_d;
      srst_q <= srst_d;  nien_q <= nien_d;  irq_q <= irq_d;
      cmdv_q <= cmdv_d;  opc_q <= opc_d;  brd_q <= brd_d;  bwr_q <= bwr_d;  bw_q <= bw_d;
    end
  end

  assign err_o = err_q;    assign scnt_o = scnt_q;    assign snum_o = snum_q;
  assign cyllo_o = cyllo_q; assign cylhi_o = cylhi_q; assign drv_o = drv_q;
  assign head_o = head_q;  assign srst_o = srst_q;    assign nien_o = nien_q;
  assign irq_o = irq_q;    assign cmdv_o = cmdv_q;    assign opc_o = opc_q;
  assign brd_o = brd_q;    assign bwr_o = bwr_q;      assign bwdata_o = bw_q;
endmodule

// File: rtl/pata_tf_rdmux.sv
module pata_tf_rdmux
  import pata_tf_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  tf_sel_t              sel,
  input  logic                 rd_active,
  input  logic                 busy_eff,
  input  logic                 dev_drq,
  input  logic [TF_BYTE_W-1:0] status,
  input  logic [TF_BYTE_W-1:0] err,
  input  logic [TF_BYTE_W-1:0] scnt,
  input  logic [TF_BYTE_W-1:0] snum,
  input  logic [TF_BYTE_W-1:0] cyllo,
  input  logic [TF_BYTE_W-1:0] cylhi,
  input  logic                 drv,
  input  logic [3:0]           head,
  input  logic                 wgate,
  input  logic [DATA_W-1:0]    buf_rdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [DATA_W-1:0]    oe
);
  localparam int unsigned PAD_W = DATA_W - TF_BYTE_W;
  localparam logic [DATA_W-1:0] OE_BYTE = {{PAD_W{1'b0}}, {TF_BYTE_W{1'b1}}};
  localparam logic [DATA_W-1:0] OE_DADR = {{(PAD_W+1){1'b0}}, {(TF_BYTE_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] OE_WORD = {DATA_W{1'b1}};

  logic [TF_BYTE_W-1:0] byte_v;
  logic [TF_BYTE_W-1:0] dh_byte, dadr_byte;

  always_comb begin
    dh_byte   = {3'b101, drv, head};
    dadr_byte = {1'b0, ~wgate, ~head, ~drv, drv};
    byte_v = '0;
    rdata  = '0;
    oe     = '0;
    if (rd_active && sel.cmd_sel) begin
      if (busy_eff) begin
        byte_v = status;
        oe     = OE_BYTE;
      end else if (sel.addr == CA_DATA) begin
        oe = OE_WORD;
        if (dev_drq) rdata = buf_rdata;
      end else begin
        oe = OE_BYTE;
        case (sel.addr)
          CA_PRECMP: byte_v = err;
          CA_SCNT:   byte_v = scnt;
          CA_SNUM:   byte_v = snum;
          CA_CYLLO:  byte_v = cyllo;
          CA_CYLHI:  byte_v = cylhi;
          CA_DRVHD:  byte_v = dh_byte;
          default:   byte_v = status;
        endcase
      end
    end else if (rd_active && sel.ctl_sel) begin
      if (sel.addr == KA_ALTDEV) begin
        byte_v = status;
        oe     = OE_BYTE;
      end else if (sel.addr == KA_DRVADR) begin
        byte_v = dadr_byte;
        oe     = OE_DADR;
      end
    end
    if (oe != OE_WORD) rdata = {{PAD_W{1'b0}}, byte_v};
  end
endmodule

// File: rtl/pata_taskfile.sv
module pata_taskfile
  import pata_tf_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_cs_cmd_n,
  input  logic                 host_cs_ctl_n,
  input  logic [2:0]           host_addr,
  input  logic                 host_rd_n,
  input  logic                 host_wr_n,
  input  logic [15:0]          host_wdata,
  output logic [15:0]          host_rdata,
  output logic [15:0]          host_rd_oe,
  output logic                 host_iocs16_n,
  output logic                 host_irq,
  output logic                 host_irq_oe,
  input  logic                 drive_id,
  input  logic [7:0]           dev_status,
  input  logic                 dev_wgate,
  input  logic                 dev_irq_set,
  input  logic                 dev_err_load,
  input  logic [7:0]           dev_err_code,
  output logic [7:0]           tf_sect_cnt,
  output logic [7:0]           tf_sect_num,
  output logic [15:0]          tf_cyl,
  output logic                 tf_drv,
  output logic [3:0]           tf_head,
  output logic                 srst_out,
  output logic                 cmd_valid,
  output logic [7:0]           cmd_opcode,
  input  logic [15:0]          buf_rdata,
  output logic                 buf_rd_pulse,
  output logic [15:0]          buf_wdata,
  output logic                 buf_wr_pulse
);
  localparam int unsigned BUNDLE_W = 2 + TF_ADDR_W + 2 + DATA_W;

  logic [BUNDLE_W-1:0] bundle_in, bundle_s;
  logic                s_cs_cmd_n, s_cs_ctl_n, s_rd_n, s_wr_n;
  logic [TF_ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0]   s_wdata;
  tf_sel_t             sel;
  logic                rd_active, rd_start, rd_end, wr_end;
  logic                busy_eff, nien, drv;
  logic [TF_BYTE_W-1:0] err, scnt, snum, cyllo, cylhi, status;
  logic [3:0]          head;
  logic [DATA_W-1:0]   rdata_d, oe_d, rdata_q, oe_q;
  logic                iocs_d, iocs_q;

  assign bundle_in = {host_cs_cmd_n, host_cs_ctl_n, host_addr, host_rd_n, host_wr_n, host_wdata};

  pata_sync #(.WIDTH(BUNDLE_W), .STAGES(SYNC_STAGES), .RST_VAL({BUNDLE_W{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bundle_in), .q(bundle_s)
  );

  assign {s_cs_cmd_n, s_cs_ctl_n, s_addr, s_rd_n, s_wr_n, s_wdata} = bundle_s;

  pata_tf_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_cmd_n(s_cs_cmd_n), .cs_ctl_n(s_cs_ctl_n),
    .addr(s_addr), .rd_n(s_rd_n), .wr_n(s_wr_n), .sel(sel),
    .rd_active(rd_active), .rd_start(rd_start), .rd_end(rd_end), .wr_end(wr_end)
  );

  pata_tf_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_start(rd_start), .rd_end(rd_end),
    .wr_end(wr_end), .wdata(s_wdata), .dev_busy(dev_status[ST_BUSY]),
    .dev_drq(dev_status[ST_DRQ]), .dev_irq_set(dev_irq_set),
    .dev_err_load(dev_err_load), .dev_err_code(dev_err_code),
    .busy_eff(busy_eff), .err_o(err), .scnt_o(scnt), .snum_o(snum),
    .cyllo_o(cyllo), .cylhi_o(cylhi), .drv_o(drv), .head_o(head),
    .srst_o(srst_out), .nien_o(nien), .irq_o(host_irq), .cmdv_o(cmd_valid),
    .opc_o(cmd_opcode), .brd_o(buf_rd_pulse), .bwr_o(buf_wr_pulse), .bwdata_o(buf_wdata)
  );

  assign status = {busy_eff, dev_status[ST_BUSY-1:0]};

  pata_tf_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .sel(sel), .rd_active(rd_active), .busy_eff(busy_eff), .dev_drq(dev_status[ST_DRQ]),
    .status(status), .err(err), .scnt(scnt), .snum(snum), .cyllo(cyllo),
    .cylhi(cylhi), .drv(drv), .head(head), .wgate(dev_wgate),
    .buf_rdata(buf_rdata), .rdata(rdata_d), .oe(oe_d)
  );

  assign iocs_d = !(sel.cmd_sel && (sel.addr == CA_DATA) && dev_status[ST_DRQ] && !busy_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      oe_q    <= '0;
      iocs_q  <= 1'b1;
    end else begin
      rdata_q <= rdata_d;
      oe_q    <= oe_d;
      iocs_q  <= iocs_d;
    end
  end

  assign host_rdata    = rdata_q;
  assign host_rd_oe    = oe_q;
  assign host_iocs16_n = iocs_q;
  assign host_irq_oe   = !nien && (drv == drive_id);
  assign tf_sect_cnt   = scnt;
  assign tf_sect_num   = snum;
  assign tf_cyl        = {cylhi, cyllo};
  assign tf_drv        = drv;
  assign tf_head       = head;
endmodule

// File: rtl/pata_tf_chk.sv
module pata_tf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        dev_busy,
  input logic        dev_drq,
  input logic        srst_out,
  input logic        host_irq,
  input logic        buf_rd_pulse,
  input logic        buf_wr_pulse,
  input logic [15:0] host_rd_oe
);
  // R5
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R4
  cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (!$past(dev_busy) && !$past(srst_out)));

  // R9
  irq_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_out |=> !host_irq);

  // R11
  buf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_rd_pulse && buf_wr_pulse));

  // R11
  buf_wr_drq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_pulse |-> ($past(dev_drq) && !$past(dev_busy) && !$past(srst_out)));

  // R6
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_oe == 16'h0000) || (host_rd_oe == 16'h00FF) ||
    (host_rd_oe == 16'h007F) || (host_rd_oe == 16'hFFFF));
endmodule

bind pata_taskfile pata_tf_chk u_tf_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .dev_busy(dev_status[7]),
  .dev_drq(dev_status[3]), .srst_out(srst_out), .host_irq(host_irq),
  .buf_rd_pulse(buf_rd_pulse), .buf_wr_pulse(buf_wr_pulse), .host_rd_oe(host_rd_oe)
);

// File: tb/tb_pata_taskfile.sv
`timescale 1ns/1ps
module tb_pata_taskfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs_cmd_n = 1'b1, host_cs_ctl_n = 1'b1;
  logic [2:0]  host_addr = '0;
  logic        host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata, host_rd_oe;
  logic        host_iocs16_n, host_irq, host_irq_oe;
  logic        drive_id = 1'b0;
  logic [7:0]  dev_status = 8'h50;
  logic        dev_wgate = 1'b0, dev_irq_set = 1'b0, dev_err_load = 1'b0;
  logic [7:0]  dev_err_code = '0;
  logic [7:0]  tf_sect_cnt, tf_sect_num, cmd_opcode;
  logic [15:0] tf_cyl, buf_wdata;
  logic        tf_drv, srst_out, cmd_valid, buf_rd_pulse, buf_wr_pulse;
  logic [3:0]  tf_head;
  logic [15:0] buf_rdata = 16'h0000;

  int checks = 0, fails = 0;
  int cmd_cnt = 0, bwr_cnt = 0, brd_cnt = 0;
  logic [7:0]  last_op = '0;
  logic [15:0] last_bw = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pata_taskfile dut (.*);

  always @(posedge clk) begin
    if (cmd_valid)    begin cmd_cnt++; last_op = cmd_opcode; end
    if (buf_wr_pulse) begin bwr_cnt++; last_bw = buf_wdata; end
    if (buf_rd_pulse) brd_cnt++;
  end

  task automatic check_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sel bit0: command block chip select, bit1: control block chip select
  task automatic host_wr(input logic [1:0] s, input logic [2:0] a, input logic [15:0] d);
    host_cs_cmd_n = ~s[0]; host_cs_ctl_n = ~s[1]; host_addr = a; host_wdata = d;
    cyc(4); host_wr_n = 1'b0; cyc(4); host_wr_n = 1'b1; cyc(6);
    host_cs_cmd_n = 1'b1; host_cs_ctl_n = 1'b1; cyc(3);
  endtask

  task automatic host_rd(input logic [1:0] s, input logic [2:0] a,
                         output logic [15:0] d, output logic [15:0] oe);
    host_cs_cmd_n = ~s[0]; host_cs_ctl_n = ~s[1]; host_addr = a;
    cyc(4); host_rd_n = 1'b0; cyc(6); d = host_rdata; oe = host_rd_oe;
    host_rd_n = 1'b1; cyc(6);
    host_cs_cmd_n = 1'b1; host_cs_ctl_n = 1'b1; cyc(3);
  endtask

  task automatic rd_chk(input string req, input logic [1:0] s, input logic [2:0] a,
                        input logic [15:0] exp, input logic [15:0] exp_oe);
    logic [15:0] d, oe;
    host_rd(s, a, d, oe);
    check_eq(req, d & exp_oe, exp);
    check_eq({req, " oe"}, oe, exp_oe);
  endtask

  task automatic t_reset;
    rd_chk("R1 err",  2'b01, 3'd1, 16'h0001, 16'h00FF);
    rd_chk("R1 scnt", 2'b01, 3'd2, 16'h0001, 16'h00FF);
    rd_chk("R1 snum", 2'b01, 3'd3, 16'h0001, 16'h00FF);
    rd_chk("R1 cyl",  2'b01, 3'd4, 16'h0000, 16'h00FF);
    rd_chk("R1 cylh", 2'b01, 3'd5, 16'h0000, 16'h00FF);
    rd_chk("R1 dh",   2'b01, 3'd6, 16'h00A0, 16'h00FF);
    rd_chk("R4 status", 2'b01, 3'd7, 16'h0050, 16'h00FF);
  endtask

  task automatic t_regs;
    host_wr(2'b01, 3'd2, 16'h0012);
    host_wr(2'b01, 3'd3, 16'h0034);
    host_wr(2'b01, 3'd4, 16'h0056);
    host_wr(2'b01, 3'd5, 16'h0078);
    host_wr(2'b01, 3'd6, 16'h00FF);
    rd_chk("R2 scnt", 2'b01, 3'd2, 16'h0012, 16'h00FF);
    rd_chk("R2 snum", 2'b01, 3'd3, 16'h0034, 16'h00FF);
    rd_chk("R2 cyll", 2'b01, 3'd4, 16'h0056, 16'h00FF);
    rd_chk("R2 cylh", 2'b01, 3'd5, 16'h0078, 16'h00FF);
    rd_chk("R3 dh fixed bits", 2'b01, 3'd6, 16'h00BF, 16'h00FF);
    check_eq("R2 tf_cyl", tf_cyl, 16'h7856);
    host_wr(2'b01, 3'd6, 16'h0005);
    rd_chk("R3 dh drv0", 2'b01, 3'd6, 16'h00A5, 16'h00FF);
  endtask

  task automatic t_cmd;
    int c0 = cmd_cnt;
    host_wr(2'b01, 3'd1, 16'h005A);
    rd_chk("R5 precomp ignored", 2'b01, 3'd1, 16'h0001, 16'h00FF);
    check_eq("R5 precomp no cmd", 16'(cmd_cnt - c0), 16'd0);
    host_wr(2'b01, 3'd7, 16'h00EC);
    check_eq("R5 one pulse", 16'(cmd_cnt - c0), 16'd1);
    check_eq("R5 opcode", {8'h00, last_op}, 16'h00EC);
  endtask

  task automatic t_busy;
    int c0 = cmd_cnt;
    dev_status = 8'hD0;
    host_wr(2'b01, 3'd2, 16'h0099);
    host_wr(2'b01, 3'd7, 16'h0020);
    rd_chk("R4 sc reads status", 2'b01, 3'd2, 16'h00D0, 16'h00FF);
    rd_chk("R4 data reads status", 2'b01, 3'd0, 16'h00D0, 16'h00FF);
    check_eq("R4 cmd ignored", 16'(cmd_cnt - c0), 16'd0);
    dev_status = 8'h50;
    rd_chk("R4 sc kept", 2'b01, 3'd2, 16'h0012, 16'h00FF);
  endtask

  task automatic t_ctl;
    // drive/head currently drv0 head 5
    dev_status = 8'h51;
    rd_chk("R6 alt status", 2'b10, 3'd6, 16'h0051, 16'h00FF);
    dev_wgate = 1'b0;
    rd_chk("R6 drive addr", 2'b10, 3'd7, 16'h006A, 16'h007F);
    host_wr(2'b01, 3'd6, 16'h001F);
    dev_wgate = 1'b1;
    rd_chk("R6 drive addr drv1", 2'b10, 3'd7, 16'h0001, 16'h007F);
    dev_wgate = 1'b0;
    rd_chk("R6 float addr2", 2'b10, 3'd2, 16'h0000, 16'h0000);
    host_wr(2'b01, 3'd6, 16'h0005);
    dev_status = 8'h50;
  endtask

  task automatic t_illegal;
    host_wr(2'b11, 3'd2, 16'h00EE);
    host_wr(2'b00, 3'd2, 16'h00DD);
    rd_chk("R7 both low float", 2'b11, 3'd2, 16'h0000, 16'h0000);
    rd_chk("R7 none float", 2'b00, 3'd2, 16'h0000, 16'h0000);
    rd_chk("R7 sc kept", 2'b01, 3'd2, 16'h0012, 16'h00FF);
  endtask

  task automatic pulse_irq;
    @(negedge clk); dev_irq_set = 1'b1; @(negedge clk); dev_irq_set = 1'b0; cyc(2);
  endtask

  task automatic t_irq;
    logic [15:0] d, oe;
    int c0;
    host_wr(2'b10, 3'd6, 16'h0008);
    check_eq("R10 oe enabled", {15'd0, host_irq_oe}, 16'd1);
    host_wr(2'b10, 3'd3, 16'h000A);
    check_eq("R6 ctl addr3 write ignored", {15'd0, host_irq_oe}, 16'd1);
    pulse_irq();
    check_eq("R9 set", {15'd0, host_irq}, 16'd1);
    host_rd(2'b10, 3'd6, d, oe);
    check_eq("R9 alt read keeps", {15'd0, host_irq}, 16'd1);
    host_rd(2'b01, 3'd7, d, oe);
    check_eq("R9 status read clears", {15'd0, host_irq}, 16'd0);
    pulse_irq();
    c0 = cmd_cnt;
    host_wr(2'b01, 3'd7, 16'h0091);
    check_eq("R9 cmd write clears", {15'd0, host_irq}, 16'd0);
    check_eq("R5 cmd 91", {8'h00, last_op}, 16'h0091);
    pulse_irq();
    host_wr(2'b10, 3'd6, 16'h000C);
    check_eq("R9 srst clears", {15'd0, host_irq}, 16'd0);
    check_eq("R8 srst out", {15'd0, srst_out}, 16'd1);
    rd_chk("R8 busy while srst", 2'b01, 3'd2, 16'h00D0, 16'h00FF);
    host_wr(2'b10, 3'd6, 16'h0008);
    rd_chk("R8 sc back to reset", 2'b01, 3'd2, 16'h0001, 16'h00FF);
    rd_chk("R8 dh back to reset", 2'b01, 3'd6, 16'h00A0, 16'h00FF);
    host_wr(2'b10, 3'd6, 16'h000A);
    check_eq("R10 nien set", {15'd0, host_irq_oe}, 16'd0);
    host_wr(2'b10, 3'd6, 16'h0008);
    host_wr(2'b01, 3'd6, 16'h0010);
    check_eq("R10 other drive", {15'd0, host_irq_oe}, 16'd0);
    drive_id = 1'b1; cyc(1);
    check_eq("R10 drive id match", {15'd0, host_irq_oe}, 16'd1);
    drive_id = 1'b0;
    check_eq("R9 cmd count", 16'(cmd_cnt - c0), 16'd1);
  endtask

  task automatic t_data;
    logic [15:0] d, oe;
    int w0 = bwr_cnt, r0 = brd_cnt;
    dev_status = 8'h50;
    host_wr(2'b01, 3'd0, 16'h1234);
    host_rd(2'b01, 3'd0, d, oe);
    check_eq("R11 no drq no wr", 16'(bwr_cnt - w0), 16'd0);
    check_eq("R11 no drq no rd", 16'(brd_cnt - r0), 16'd0);
    dev_status = 8'h58;
    buf_rdata  = 16'hCAFE;
    host_cs_cmd_n = 1'b0; host_addr = 3'd0; cyc(5);
    check_eq("R11 iocs16 low", {15'd0, host_iocs16_n}, 16'd0);
    host_cs_cmd_n = 1'b1; cyc(5);
    check_eq("R11 iocs16 high", {15'd0, host_iocs16_n}, 16'd1);
    host_wr(2'b01, 3'd0, 16'hBEEF);
    check_eq("R11 wr pulse", 16'(bwr_cnt - w0), 16'd1);
    check_eq("R11 wr data", last_bw, 16'hBEEF);
    rd_chk("R11 word read", 2'b01, 3'd0, 16'hCAFE, 16'hFFFF);
    check_eq("R11 rd pulse", 16'(brd_cnt - r0), 16'd1);
    dev_status = 8'h50;
  endtask

  task automatic t_err;
    @(negedge clk); dev_err_code = 8'h84; dev_err_load = 1'b1;
    @(negedge clk); dev_err_load = 1'b0; dev_err_code = 8'h00;
    rd_chk("R12 err load", 2'b01, 3'd1, 16'h0084, 16'h00FF);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    check_eq("R1 idle oe", host_rd_oe, 16'h0000);
    check_eq("R11 iocs16 reset", {15'd0, host_iocs16_n}, 16'd1);
    t_reset();
    t_regs();
    t_cmd();
    t_busy();
    t_ctl();
    t_illegal();
    t_irq();
    t_data();
    t_err();
    finish_run();
  end
endmodule